// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability with Per-Vector Masking

This block is the message-signalled interrupt capability of one PCIe-style function. It holds the configuration dwords that software programs: a control dword, a message address, a message data value, a vector mask and a read-only pending set. User logic raises per-vector interrupt requests. The block turns each accepted request into one memory-write request on a valid/ready output. That request carries the programmed address and the programmed data, with the vector number placed in the low data bits.

Software decides how many vectors are in use, up to a limit fixed at build time. Vectors that are masked, or that arrive while interrupts are disabled, stay parked in the pending set. They go out once they become eligible. A build-time switch selects 64-bit addressing, and the positions of the data, mask and pending dwords move with that switch.

Top module: `msi_cap`

## Requirements
- R1: After reset the control dword at 0x050 reads: [7:0]=0x05, [15:8]=NEXT_PTR, [16]=0 (enable), [19:17]=MMC, [22:20]=0, [23]=CAP_64, [24]=1, [31:25]=0.
- R2: A control write whose field [22:20] exceeds MMC stores MMC in that field. Otherwise the written value is stored. Field value k means 2^k vectors are enabled.
- R3: Control bit 16 is the interrupt enable and is writable. While it is 0 no new message starts, and accepted requests stay in the pending set.
- R4: The lower address dword at 0x054 stores bits [31:2] of a write, and its bits [1:0] read 0.
- R5: With CAP_64=1 the upper address is at 0x058, data at 0x05C, mask at 0x060 and pending at 0x064. With CAP_64=0 the data is at 0x058, the mask at 0x05C and pending at 0x060. Any other offset reads 0.
- R6: The message address is {upper, lower} with CAP_64=1, and {32'h0, lower} with CAP_64=0.
- R7: The data dword stores bits [15:0], and bits [31:16] read 0. The emitted data is {16'h0, data} with its low k bits replaced by the vector number.
- R8: Mask and pending reads show only bits below the enabled vector count 2^k. Higher bits read 0. Pending ignores writes.
- R9: A request on vector v with v >= 2^k is ignored: it does not appear in pending and sends no message.
- R10: A request on a vector whose mask bit is 1 sets its pending bit and sends nothing. Clearing that mask bit (with enable set) sends the message and clears the bit.
- R11: msg_valid_o stays high with stable address and data until msg_ready_i is sampled high. At most one message is outstanding, and a new one starts only in a cycle where none is held.
- R12: Among pending, unmasked, enabled vectors the lowest number is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 12 | Configuration byte offset (dword aligned) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i (combinational) |
| irq_req_i | input | 32 | Per-vector interrupt request pulses |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 64 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The hardest state to reach is a pending vector that becomes eligible through a side path rather than through its own request. This can happen when a mask bit clears, when the enable bit rises, or when a control write changes the vector count while other vectors are queued or a message is stalled. The stimulus first builds such states on purpose: it masks a group of vectors, fires them all in one cycle, holds ready low, and then unmasks or regrows the vector count. A long random phase follows that mixes writes to every offset with sparse requests and random ready. A behavioural model is compared against the outputs and the read port on every cycle.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int CFG_AW  = 12;
  localparam int NUM_VEC = 32;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int MME_W   = 3;
  localparam int DATA_W  = 16;

  localparam logic [CFG_AW-1:0] OFF_CTRL  = 12'h050;
  localparam logic [CFG_AW-1:0] OFF_ADDR  = 12'h054;
  localparam logic [CFG_AW-1:0] OFF_SLOT2 = 12'h058;
  localparam logic [CFG_AW-1:0] OFF_SLOT3 = 12'h05C;
  localparam logic [CFG_AW-1:0] OFF_SLOT4 = 12'h060;
  localparam logic [CFG_AW-1:0] OFF_SLOT5 = 12'h064;
  localparam logic [7:0]        CAP_ID    = 8'h05;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  // vectors below 2^k
  function automatic logic [NUM_VEC-1:0] vec_enable_mask(input logic [MME_W-1:0] k);
    vec_enable_mask = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (i < (1 << int'(k))) vec_enable_mask[i] = 1'b1;
  endfunction

  // low data bits that carry the vector number
  function automatic logic [VEC_W-1:0] num_field_mask(input logic [MME_W-1:0] k);
    num_field_mask = '0;
    for (int i = 0; i < VEC_W; i++)
      if (i < int'(k)) num_field_mask[i] = 1'b1;
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter bit               CAP_64   = 1'b1,
  parameter logic [MME_W-1:0] MMC      = 3'd5,
  parameter logic [7:0]       NEXT_PTR = 8'h68
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] pend_i,
  output logic [MME_W-1:0]   mme_o,
  output logic               msi_en_o,
  output logic [63:0]        msg_addr_o,
  output logic [DATA_W-1:0]  msg_base_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] en_mask_o
);
  localparam logic [CFG_AW-1:0] OFF_DATA = CAP_64 ? OFF_SLOT3 : OFF_SLOT2;
  localparam logic [CFG_AW-1:0] OFF_MASK = CAP_64 ? OFF_SLOT4 : OFF_SLOT3;
  localparam logic [CFG_AW-1:0] OFF_PEND = CAP_64 ? OFF_SLOT5 : OFF_SLOT4;

  logic [MME_W-1:0]   mme_q, mme_wr;
  logic               en_q;
  logic [29:0]        lo_q;
  logic [31:0]        hi_q;
  logic [DATA_W-1:0]  data_q;
  logic [NUM_VEC-1:0] mask_q;
  logic               hit_ctrl, hit_lo, hit_hi, hit_data, hit_mask, hit_pend;

  assign hit_ctrl = cfg_addr_i == OFF_CTRL;
  assign hit_lo   = cfg_addr_i == OFF_ADDR;
  assign hit_hi   = CAP_64 && (cfg_addr_i == OFF_SLOT2);
  assign hit_data = cfg_addr_i == OFF_DATA;
  assign hit_mask = cfg_addr_i == OFF_MASK;
  assign hit_pend = cfg_addr_i == OFF_PEND;

  assign mme_wr = (cfg_wdata_i[22:20] > MMC) ? MMC : cfg_wdata_i[22:20];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mme_q  <= '0;
      en_q   <= 1'b0;
      lo_q   <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (cfg_wr_i) begin
      if (hit_ctrl) begin
        mme_q <= mme_wr;
        en_q  <= cfg_wdata_i[16];
      end
      if (hit_lo)   lo_q   <= cfg_wdata_i[31:2];
      if (hit_data) data_q <= cfg_wdata_i[DATA_W-1:0];
      if (hit_mask) mask_q <= cfg_wdata_i;
    end
  end

  generate
    if (CAP_64) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  hi_q <= '0;
        else if (cfg_wr_i && hit_hi)  hi_q <= cfg_wdata_i;
      end
    end else begin : g_no_hi
      assign hi_q = '0;
    end
  endgenerate

  assign en_mask_o  = vec_enable_mask(mme_q);
  assign mme_o      = mme_q;
  assign msi_en_o   = en_q;
  assign msg_addr_o = {hi_q, lo_q, 2'b00};
  assign msg_base_o = data_q;
  assign mask_o     = mask_q;

  always_comb begin
    cfg_rdata_o = '0;
    if (hit_ctrl)      cfg_rdata_o = {7'b0, 1'b1, CAP_64, mme_q, MMC, en_q, NEXT_PTR, CAP_ID};
    else if (hit_lo)   cfg_rdata_o = {lo_q, 2'b00};
    else if (hit_hi)   cfg_rdata_o = hi_q;
    else if (hit_data) cfg_rdata_o = {{(32-DATA_W){1'b0}}, data_q};
    else if (hit_mask) cfg_rdata_o = mask_q & en_mask_o;
    else if (hit_pend) cfg_rdata_o = pend_i & en_mask_o;
  end

  assert_mme_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mme_q <= MMC);
endmodule

// File: rtl/msi_vec_arb.sv
module msi_vec_arb
  import msi_cap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic [NUM_VEC-1:0] en_mask_i,
  input  logic               allow_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               grant_o,
  output logic [VEC_W-1:0]   grant_idx_o
);
  logic [NUM_VEC-1:0] pend_q, pend_d, cand, grant_oh;

  assign cand = pend_q & ~mask_i & en_mask_i;

  always_comb begin
    grant_idx_o = '0;
    for (int i = NUM_VEC-1; i >= 0; i--)
      if (cand[i]) grant_idx_o = VEC_W'(i);
  end

  assign grant_o  = allow_i && (|cand);
  assign grant_oh = grant_o ? (NUM_VEC'(1) << grant_idx_o) : '0;
  // requests above the enabled count fall out here
  assign pend_d   = ((pend_q & ~grant_oh) | req_i) & en_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_grant_unmasked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (!mask_i[grant_idx_o] && pend_q[grant_idx_o]));
  assert_grant_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> en_mask_i[grant_idx_o]);
  assert_grant_lowest_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ((cand & ((NUM_VEC'(1) << grant_idx_o) - NUM_VEC'(1))) == '0));
  assert_grant_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_oh));
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic [VEC_W-1:0]  grant_idx_i,
  input  logic [MME_W-1:0]  mme_i,
  input  logic              msi_en_i,
  input  logic [63:0]       addr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              busy_o,
  output logic [63:0]       addr_o,
  output logic [31:0]       data_o
);
  localparam int PAD = DATA_W - VEC_W;

  logic              valid_q;
  msi_msg_t          msg_q;
  logic [DATA_W-1:0] fmask, merged;

  assign fmask  = {{PAD{1'b0}}, num_field_mask(mme_i)};
  assign merged = (base_i & ~fmask) | ({{PAD{1'b0}}, grant_idx_i} & fmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (grant_i) begin
      valid_q    <= 1'b1;
      msg_q.addr <= addr_i;
      msg_q.data <= {{(32-DATA_W){1'b0}}, merged};
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign busy_o  = valid_q;
  assign addr_o  = msg_q.addr;
  assign data_o  = msg_q.data;

  assert_msg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(msg_q)));
  assert_no_grant_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> !valid_q);
  assert_launch_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(msi_en_i));
  assert_data_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (data_o[31:DATA_W] == '0));
endmodule

// File: rtl/msi_cap.sv
module msi_cap
  import msi_cap_pkg::*;
#(
  parameter bit               CAP_64   = 1'b1,
  parameter logic [MME_W-1:0] MMC      = 3'd5,
  parameter logic [7:0]       NEXT_PTR = 8'h68
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] irq_req_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic [MME_W-1:0]   mme;
  logic               msi_en, busy, grant;
  logic [63:0]        prog_addr;
  logic [DATA_W-1:0]  prog_base;
  logic [NUM_VEC-1:0] mask, en_mask, pend;
  logic [VEC_W-1:0]   grant_idx;

  msi_cfg_regs #(.CAP_64(CAP_64), .MMC(MMC), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .pend_i(pend), .mme_o(mme), .msi_en_o(msi_en), .msg_addr_o(prog_addr),
    .msg_base_o(prog_base), .mask_o(mask), .en_mask_o(en_mask)
  );

  msi_vec_arb u_arb (
    .clk_i, .rst_ni, .req_i(irq_req_i), .mask_i(mask), .en_mask_i(en_mask),
    .allow_i(msi_en && !busy), .pend_o(pend), .grant_o(grant), .grant_idx_o(grant_idx)
  );

  msi_msg_out u_out (
    .clk_i, .rst_ni, .grant_i(grant), .grant_idx_i(grant_idx), .mme_i(mme),
    .msi_en_i(msi_en), .addr_i(prog_addr), .base_i(prog_base), .ready_i(msg_ready_i),
    .valid_o(msg_valid_o), .busy_o(busy), .addr_o(msg_addr_o), .data_o(msg_data_o)
  );
endmodule

// File: tb/msi_cap_bench.sv
module msi_cap_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [11:0] cfg_addr_i = 12'h050;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [31:0] irq_req_i = '0;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b0;
  logic [63:0] msg_addr_o;
  logic [31:0] msg_data_o;

  logic        b_wr = 1'b0;
  logic [11:0] b_addr = 12'h050;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic [31:0] b_req = '0;
  logic        b_valid;
  logic [63:0] b_maddr;
  logic [31:0] b_mdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  msi_cap u_msi_cap (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .irq_req_i, .msg_valid_o, .msg_ready_i, .msg_addr_o, .msg_data_o
  );

  msi_cap #(.CAP_64(1'b0), .MMC(3'd2), .NEXT_PTR(8'h78)) u_msi_cap_b (
    .clk_i, .rst_ni, .cfg_wr_i(b_wr), .cfg_addr_i(b_addr), .cfg_wdata_i(b_wdata),
    .cfg_rdata_o(b_rdata), .irq_req_i(b_req), .msg_valid_o(b_valid), .msg_ready_i(1'b1),
    .msg_addr_o(b_maddr), .msg_data_o(b_mdata)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference for u_msi_cap ----------------
  int          m_mme;
  bit          m_en, m_valid;
  bit   [31:0] m_lo, m_hi, m_mask, m_pend;
  bit   [15:0] m_data;
  bit   [63:0] m_addr;
  bit   [31:0] m_mdata;

  function automatic bit [31:0] em(input int k);
    return (k >= 5) ? 32'hFFFF_FFFF : ((32'd1 << (1 << k)) - 1);
  endfunction

  function automatic bit [31:0] mread(input bit [11:0] a);
    case (a)
      12'h050: return {7'b0, 1'b1, 1'b1, 3'(m_mme), 3'd5, m_en, 8'h68, 8'h05};
      12'h054: return m_lo;
      12'h058: return m_hi;
      12'h05C: return {16'h0, m_data};
      12'h060: return m_mask & em(m_mme);
      12'h064: return m_pend & em(m_mme);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mme = 0; m_en = 0; m_valid = 0; m_lo = 0; m_hi = 0; m_mask = 0;
      m_pend = 0; m_data = 0; m_addr = 0; m_mdata = 0;
    end else begin
      automatic int      g = -1;
      automatic bit [31:0] e = em(m_mme);
      automatic bit [31:0] km = (32'd1 << m_mme) - 1;
      if (!m_valid && m_en)
        for (int v = 0; v < 32; v++)
          if (g < 0 && m_pend[v] && !m_mask[v] && e[v]) g = v;
      if (m_valid && msg_ready_i) m_valid = 0;
      if (g >= 0) begin
        m_valid = 1;
        m_addr  = {m_hi, m_lo};
        m_mdata = {16'h0, (m_data & ~km[15:0]) | (16'(g) & km[15:0])};
      end
      m_pend = ((m_pend & ~((g >= 0) ? (32'd1 << g) : 32'd0)) | irq_req_i) & e;
      if (cfg_wr_i) begin
        case (cfg_addr_i)
          12'h050: begin
            m_mme = (cfg_wdata_i[22:20] > 3'd5) ? 5 : int'(cfg_wdata_i[22:20]);
            m_en  = cfg_wdata_i[16];
          end
          12'h054: m_lo   = {cfg_wdata_i[31:2], 2'b00};
          12'h058: m_hi   = cfg_wdata_i;
          12'h05C: m_data = cfg_wdata_i[15:0];
          12'h060: m_mask = cfg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      chk("R11 valid", 64'(msg_valid_o), 64'(m_valid));
      if (m_valid) begin
        chk("R6 address", msg_addr_o, m_addr);
        chk("R7 data", 64'(msg_data_o), 64'(m_mdata));
      end
      chk("R5 read port", 64'(cfg_rdata_o), 64'(mread(cfg_addr_i)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1;
    chk(req, 64'(cfg_rdata_o), 64'(exp));
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk_i);
    irq_req_i = v;
    @(negedge clk_i);
    irq_req_i = '0;
  endtask

  task automatic expect_msg(input string req, input logic [31:0] exp_d);
    int t = 0;
    @(negedge clk_i);
    while (!msg_valid_o && t < 200) begin
      @(negedge clk_i);
      t++;
    end
    chk(req, 64'(msg_data_o), 64'(exp_d));
    repeat (3) @(negedge clk_i);
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    msg_ready_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    rd("R1 control reset", 12'h050, 32'h018A_6805);
    rd("R8 pending reset", 12'h064, 32'h0);

    wr(12'h054, 32'hDEAD_BEEF);
    rd("R4 low address", 12'h054, 32'hDEAD_BEEC);
    wr(12'h058, 32'h1234_5678);
    rd("R5 upper address slot", 12'h058, 32'h1234_5678);
    wr(12'h05C, 32'hABCD_1235);
    rd("R7 data upper zero", 12'h05C, 32'h0000_1235);

    // disabled, one vector: vec1 is out of range
    pulse(32'h3);
    repeat (3) @(negedge clk_i);
    rd("R9 R3 pending held", 12'h064, 32'h1);
    chk("R3 no message while disabled", 64'(msg_valid_o), 64'h0);

    wr(12'h050, 32'h0001_0000);
    expect_msg("R3 sent on enable", 32'h0000_1235);

    wr(12'h050, 32'h0031_0000);
    wr(12'h060, 32'h0);
    pulse(32'h0000_00A4);
    expect_msg("R12 first vec2", 32'h1232);
    expect_msg("R12 second vec5", 32'h1235);
    expect_msg("R12 third vec7", 32'h1237);

    wr(12'h060, 32'h0000_000F);
    pulse(32'h1000_00FF);
    expect_msg("R10 vec4", 32'h1234);
    expect_msg("R10 vec5", 32'h1235);
    expect_msg("R10 vec6", 32'h1236);
    expect_msg("R10 vec7", 32'h1237);
    repeat (4) @(negedge clk_i);
    rd("R10 masked pending", 12'h064, 32'h0000_000F);
    wr(12'h060, 32'hFFFF_FFFB);
    rd("R8 mask width", 12'h060, 32'h0000_00FB);
    expect_msg("R10 unmask vec2", 32'h1232);
    rd("R10 pending cleared", 12'h064, 32'h0000_000B);

    wr(12'h050, 32'h0071_0000);
    rd("R2 clamp", 12'h050, 32'h01DB_6805);
    rd("R8 mask grown", 12'h060, 32'hFFFF_FFFB);
    wr(12'h060, 32'h0);
    expect_msg("R7 vec0 k5", 32'h1220);
    expect_msg("R7 vec1 k5", 32'h1221);
    expect_msg("R7 vec3 k5", 32'h1223);

    // random mix checked cycle by cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      msg_ready_i = $urandom_range(0, 2) != 0;
      irq_req_i   = $urandom & $urandom & $urandom;
      cfg_wr_i    = $urandom_range(0, 7) == 0;
      case ($urandom_range(0, 7))
        0: cfg_addr_i = 12'h050;
        1: cfg_addr_i = 12'h054;
        2: cfg_addr_i = 12'h058;
        3: cfg_addr_i = 12'h05C;
        4, 5: cfg_addr_i = 12'h060;
        6: cfg_addr_i = 12'h064;
        default: cfg_addr_i = 12'h04C;
      endcase
      cfg_wdata_i = $urandom;
      if (cfg_addr_i == 12'h050) cfg_wdata_i[16] = $urandom_range(0, 3) != 0;
    end
    @(negedge clk_i);
    cfg_wr_i = 1'b0; irq_req_i = '0; msg_ready_i = 1'b1;
    repeat (50) @(negedge clk_i);

    // 32-bit address variant
    @(negedge clk_i); b_addr = 12'h050; #1;
    chk("R1 control reset b", 64'(b_rdata), 64'h0104_7805);
    @(negedge clk_i); b_wr = 1'b1; b_addr = 12'h050; b_wdata = 32'h0041_0000;
    @(negedge clk_i); b_wr = 1'b0; #1;
    chk("R2 clamp b", 64'(b_rdata), 64'h0125_7805);
    @(negedge clk_i); b_wr = 1'b1; b_addr = 12'h054; b_wdata = 32'h0000_1003;
    @(negedge clk_i); b_addr = 12'h058; b_wdata = 32'hFFFF_A5A4;
    @(negedge clk_i); b_addr = 12'h05C; b_wdata = 32'hFFFF_FFF0;
    @(negedge clk_i); b_wr = 1'b0; b_addr = 12'h058; #1;
    chk("R5 data at 0x058 b", 64'(b_rdata), 64'h0000_A5A4);
    @(negedge clk_i); b_addr = 12'h05C; #1;
    chk("R8 mask width b", 64'(b_rdata), 64'h0);
    @(negedge clk_i); b_addr = 12'h064; #1;
    chk("R5 unused offset b", 64'(b_rdata), 64'h0);
    @(negedge clk_i); b_req = 32'h0000_0020;
    @(negedge clk_i); b_req = '0;
    repeat (3) @(negedge clk_i);
    b_addr = 12'h060; #1;
    chk("R9 out of range b", 64'({b_valid, b_rdata}), 64'h0);
    @(negedge clk_i); b_req = 32'h0000_0008;
    @(negedge clk_i); b_req = '0;
    begin
      int t = 0;
      while (!b_valid && t < 50) begin
        @(negedge clk_i);
        t++;
      end
    end
    chk("R6 address 32-bit b", b_maddr, 64'h0000_0000_0000_1000);
    chk("R7 data merge b", 64'(b_mdata), 64'h0000_A5A7);
    @(negedge clk_i); #1;
    chk("R10 pending clear b", 64'(b_rdata), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule